// File: doc/BRIEF.md
# Per-Hart Message Receive Queue

This block holds the incoming messages of one hart in a multi-hart system. Other harts deposit 64-bit messages through a push port. The local hart takes them out, oldest first, through a pop port. An operation that cannot complete does not stall. Instead the block raises a one-cycle trap pulse with a cause code, and trap handling is left to software. A push into a full queue is refused, so the newest message is the one that spills to memory. A pop from an empty queue returns no data.

A supervisor-owned overflow flag records that messages were spilled to memory. While the flag is set, a pop that finds the hardware queue drained reports a distinct reload cause, so software can refill the queue from its overflow area. A flush empties the queue. Two status outputs say at all times whether a send or a receive would currently succeed, and reading them has no side effect.

Top module: `hart_msg_queue`

## Requirements
- R1: After reset the queue holds nothing: `level` is 0, `can_recv` is 0, `can_send` is 1, `ovf_flag` is 0, and `push_ack`, `pop_valid` and `trap_valid` are 0.
- R2: A push without flush into a non-full queue is accepted. `push_ack` is 1 in the cycle after the request, and `level` rises by one.
- R3: A push without flush into a full queue is refused. One cycle later `push_ack` is 0, `trap_valid` is 1 with `trap_cause` 1 (full), and the stored messages are unchanged.
- R4: A pop without flush on a non-empty queue returns the oldest stored message on `pop_data`, with `pop_valid` 1, in the cycle after the request. Messages leave in the order they were accepted.
- R5: A pop without flush on an empty queue, while `ovf_flag` is 0, gives `pop_valid` 0, `pop_data` 0, and a trap with cause 2 (empty) one cycle later.
- R6: A pop without flush on an empty queue, while `ovf_flag` is 1, traps with cause 3 (reload needed) instead of cause 2.
- R7: A set `ovf_flag` has no effect on pops while the queue holds messages. Those pops return data normally and do not trap.
- R8: A push and a pop in the same cycle on a queue that is neither empty nor full both succeed, and `level` is unchanged.
- R9: On a full queue, a simultaneous push and pop gives a successful pop and a refused push with cause 1. On an empty queue, a simultaneous push and pop gives an accepted push and a pop that traps with the empty or reload cause.
- R10: `flush` empties the queue. A push or pop in the same cycle is ignored: no acknowledge, no data and no trap. `ovf_flag` is not changed by a flush.
- R11: `can_send` equals (`level` < DEPTH) and `can_recv` equals (`level` > 0) in every cycle. Neither output alters any state.
- R12: `ovf_set` sets `ovf_flag` and `ovf_clr` clears it, effective in the next cycle. When both are high, set wins. With neither high, the flag holds.
- R13: `trap_valid` is high for one cycle per failing request, and `trap_cause` is 0 whenever `trap_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Send request from another hart |
| push_data | input | 64 | Message to store |
| push_ack | output | 1 | Previous cycle's push was accepted |
| pop_req | input | 1 | Receive request from the local hart |
| pop_valid | output | 1 | `pop_data` holds a message |
| pop_data | output | 64 | Received message, 0 when not valid |
| flush | input | 1 | Empty the queue |
| ovf_set | input | 1 | Supervisor sets the overflow flag |
| ovf_clr | input | 1 | Supervisor clears the overflow flag |
| ovf_flag | output | 1 | Current overflow flag |
| can_send | output | 1 | A push would be accepted now |
| can_recv | output | 1 | A pop would return data now |
| level | output | 4 | Stored message count |
| trap_valid | output | 1 | Trap pulse |
| trap_cause | output | 2 | 0 none, 1 full, 2 empty, 3 reload needed |

## Verification
A push and a pop can fall in the same cycle, and the outcome depends on whether the queue is partly filled, full or empty. The bench drives the two requests together in each of these three states. It judges the acknowledge, the popped value, the trap cause and the resulting `level` against the requirement for that state. It also lands a flush on top of a simultaneous push and pop. It then checks that neither request left any trace and that a following pop finds the queue empty.

// File: rtl/mbox_pkg.sv
// Package: shared definitions for the per-hart message queue.
// Assumes nothing beyond a standard compilation order (compiled first).
package mbox_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_FULL   = 2'd1,
        CAUSE_EMPTY  = 2'd2,
        CAUSE_RELOAD = 2'd3
    } trap_cause_e;

endpackage

// File: rtl/mbox_store.sv
// Module: mbox_store
// Circular message storage with read/write pointers carrying a wrap bit.
// Assumes DEPTH is a power of two and that the caller never writes when
// full nor reads when empty (guarded by the assertions below).
module mbox_store #(
    parameter int DW    = 64,
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     wr_en,
    input  logic [DW-1:0]            wr_data,
    input  logic                     rd_en,
    output logic [DW-1:0]            head,
    output logic                     full,
    output logic                     empty,
    output logic [$clog2(DEPTH):0]   level
);
    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW:0]   wptr;
    logic [AW:0]   rptr;

    // Pointer update: clear returns both pointers to the start.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (wr_en) wptr <= wptr + 1'b1;
            if (rd_en) rptr <= rptr + 1'b1;
        end
    end

    // Storage write at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_en && !clear) mem[wptr[AW-1:0]] <= wr_data;
    end

    // Status derived from the pointers.
    always_comb begin
        head  = mem[rptr[AW-1:0]];
        empty = (wptr == rptr);
        full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
        level = wptr - rptr;
    end

    a_r3_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !wr_en);
    a_r5_no_read_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !rd_en);
    a_r8_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && !clear) |=> (level == $past(level)));
    a_r11_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= DEPTH[AW:0]);

endmodule

// File: rtl/mbox_ctrl.sv
// Module: mbox_ctrl
// Decides which requests proceed and which trap this cycle.
// Assumes full and empty come from the storage and never hold together.
module mbox_ctrl
    import mbox_pkg::*;
(
    input  logic        push_valid,
    input  logic        pop_req,
    input  logic        flush,
    input  logic        full,
    input  logic        empty,
    input  logic        ovf,
    output logic        do_push,
    output logic        do_pop,
    output trap_cause_e cause
);
    // Accept/refuse decision with flush taking priority.
    always_comb begin
        do_push = push_valid && !flush && !full;
        do_pop  = pop_req && !flush && !empty;
        cause   = CAUSE_NONE;
        if (!flush) begin
            if (push_valid && full)      cause = CAUSE_FULL;
            else if (pop_req && empty)   cause = ovf ? CAUSE_RELOAD : CAUSE_EMPTY;
        end
    end
endmodule

// File: rtl/mbox_ovf.sv
// Module: mbox_ovf
// Supervisor-owned overflow flag; set has priority over clear.
// Assumes flush does not reach this module (flag survives a flush).
module mbox_ovf (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag
);
    // Flag register update.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag <= 1'b0;
        else if (set_i) flag <= 1'b1;
        else if (clr_i) flag <= 1'b0;
    end

    a_r12_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(flag));
    a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag);
endmodule

// File: rtl/hart_msg_queue.sv
// Module: hart_msg_queue
// Receive queue of one hart: push from remote senders, pop by the local
// hart, trap pulses for full/empty/reload, flush and select-style status.
// Assumes DEPTH is a power of two and at least 2.
module hart_msg_queue
    import mbox_pkg::*;
#(
    parameter int DW    = 64,
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push_valid,
    input  logic [DW-1:0]            push_data,
    output logic                     push_ack,
    input  logic                     pop_req,
    output logic                     pop_valid,
    output logic [DW-1:0]            pop_data,
    input  logic                     flush,
    input  logic                     ovf_set,
    input  logic                     ovf_clr,
    output logic                     ovf_flag,
    output logic                     can_send,
    output logic                     can_recv,
    output logic [$clog2(DEPTH):0]   level,
    output logic                     trap_valid,
    output logic [1:0]               trap_cause
);
    logic          full_w, empty_w, do_push, do_pop;
    logic [DW-1:0] head_w;
    trap_cause_e   cause_w;

    mbox_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .clear(flush),
        .wr_en(do_push), .wr_data(push_data), .rd_en(do_pop),
        .head(head_w), .full(full_w), .empty(empty_w), .level(level)
    );

    mbox_ctrl u_ctrl (
        .push_valid(push_valid), .pop_req(pop_req), .flush(flush),
        .full(full_w), .empty(empty_w), .ovf(ovf_flag),
        .do_push(do_push), .do_pop(do_pop), .cause(cause_w)
    );

    mbox_ovf u_ovf (
        .clk(clk), .rst_n(rst_n), .set_i(ovf_set), .clr_i(ovf_clr), .flag(ovf_flag)
    );

    // Select-style status straight from the storage state.
    always_comb begin
        can_send = !full_w;
        can_recv = !empty_w;
    end

    // Registered responses: acknowledge, popped data and trap pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push_ack   <= 1'b0;
            pop_valid  <= 1'b0;
            pop_data   <= '0;
            trap_valid <= 1'b0;
            trap_cause <= 2'd0;
        end else begin
            push_ack   <= do_push;
            pop_valid  <= do_pop;
            pop_data   <= do_pop ? head_w : '0;
            trap_valid <= (cause_w != CAUSE_NONE);
            trap_cause <= cause_w;
        end
    end

    a_r3_full_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !flush && full_w) |=> (trap_valid && trap_cause == 2'd1 && !push_ack));
    a_r6_reload_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_valid && !flush && empty_w && ovf_flag) |=> (trap_cause == 2'd3 && !pop_valid));
    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0 && !push_ack && !pop_valid && !trap_valid));
    a_r13_cause_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |-> (trap_cause == 2'd0));
    a_r5_no_data_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_valid |-> (pop_data == '0));
endmodule

// File: tb/sim_hart_msg_queue.sv
module sim_hart_msg_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 0, pop_req = 0, flush = 0, ovf_set = 0, ovf_clr = 0;
    logic [63:0] push_data = '0;
    logic        push_ack, pop_valid, ovf_flag, can_send, can_recv, trap_valid;
    logic [63:0] pop_data;
    logic [3:0]  level;
    logic [1:0]  trap_cause;
    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    hart_msg_queue u0 (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
        .push_ack(push_ack), .pop_req(pop_req), .pop_valid(pop_valid), .pop_data(pop_data),
        .flush(flush), .ovf_set(ovf_set), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag),
        .can_send(can_send), .can_recv(can_recv), .level(level),
        .trap_valid(trap_valid), .trap_cause(trap_cause)
    );

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, then sample at the following negedge.
    task automatic step(input logic pu, input logic po, input logic fl,
                        input logic st, input logic cl, input logic [7:0] b);
        push_valid = pu; pop_req = po; flush = fl; ovf_set = st; ovf_clr = cl;
        push_data = {8{b}};
        @(posedge clk);
        @(negedge clk);
        push_valid = 0; pop_req = 0; flush = 0; ovf_set = 0; ovf_clr = 0;
    endtask

    // push pop flush set clr byte | ack pv pbyte tv cause level
    localparam logic [29:0] VEC [13] = '{
        {5'b01000, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 2'd2, 4'd0},  // R5 empty pop
        {5'b10000, 8'h11, 1'b1, 1'b0, 8'h00, 1'b0, 2'd0, 4'd1},  // R2
        {5'b10000, 8'h22, 1'b1, 1'b0, 8'h00, 1'b0, 2'd0, 4'd2},  // R2
        {5'b11000, 8'h33, 1'b1, 1'b1, 8'h11, 1'b0, 2'd0, 4'd2},  // R8
        {5'b01000, 8'h00, 1'b0, 1'b1, 8'h22, 1'b0, 2'd0, 4'd1},  // R4
        {5'b00010, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 4'd1},  // R12 set
        {5'b01000, 8'h00, 1'b0, 1'b1, 8'h33, 1'b0, 2'd0, 4'd0},  // R7
        {5'b01000, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 2'd3, 4'd0},  // R6
        {5'b00001, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 4'd0},  // R12 clear
        {5'b01000, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 2'd2, 4'd0},  // R5
        {5'b11000, 8'h44, 1'b1, 1'b0, 8'h00, 1'b1, 2'd2, 4'd1},  // R9 empty
        {5'b11100, 8'h55, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 4'd0},  // R10
        {5'b01000, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 2'd2, 4'd0}   // R10 after
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 level", 64'(level), 0);
        chk("R1 can_recv", 64'(can_recv), 0);
        chk("R1 can_send", 64'(can_send), 1);
        chk("R1 ovf_flag", 64'(ovf_flag), 0);
        chk("R1 outputs", 64'({push_ack, pop_valid, trap_valid}), 0);

        for (int i = 0; i < 13; i++) begin
            logic [29:0] v;
            v = VEC[i];
            step(v[29], v[28], v[27], v[26], v[25], v[24:17]);
            chk($sformatf("vec%0d R2 ack", i), 64'(push_ack), 64'(v[16]));
            chk($sformatf("vec%0d R4 pop_valid", i), 64'(pop_valid), 64'(v[15]));
            chk($sformatf("vec%0d R4/R5 pop_data", i), pop_data, {8{v[14:7]}});
            chk($sformatf("vec%0d R13 trap_valid", i), 64'(trap_valid), 64'(v[6]));
            chk($sformatf("vec%0d R3/R5/R6 cause", i), 64'(trap_cause), 64'(v[5:4]));
            chk($sformatf("vec%0d R8 level", i), 64'(level), 64'(v[3:0]));
        end

        // R2/R11 fill to full
        for (int k = 0; k < 8; k++) begin
            step(1, 0, 0, 0, 0, 8'hA0 + 8'(k));
            chk("R2 fill ack", 64'(push_ack), 1);
            chk("R11 can_send", 64'(can_send), 64'(k < 7));
            chk("R11 can_recv", 64'(can_recv), 1);
        end
        chk("R2 full level", 64'(level), 8);
        // R3 push to full
        step(1, 0, 0, 0, 0, 8'hFF);
        chk("R3 ack", 64'(push_ack), 0);
        chk("R3 cause", 64'(trap_cause), 1);
        chk("R3 trap", 64'(trap_valid), 1);
        chk("R3 level", 64'(level), 8);
        // R13 pulse lasts one cycle
        step(0, 0, 0, 0, 0, 8'h00);
        chk("R13 pulse end", 64'({trap_valid, trap_cause}), 0);
        // R9 push+pop on full
        step(1, 1, 0, 0, 0, 8'hEE);
        chk("R9 pop data", pop_data, {8{8'hA0}});
        chk("R9 push refused", 64'(push_ack), 0);
        chk("R9 cause", 64'(trap_cause), 1);
        chk("R9 level", 64'(level), 7);
        // R4 drain in order
        for (int k = 1; k < 8; k++) begin
            step(0, 1, 0, 0, 0, 8'h00);
            chk("R4 order", pop_data, {8{8'hA0 + 8'(k)}});
        end
        step(0, 1, 0, 0, 0, 8'h00);
        chk("R3 refused not stored", 64'(trap_cause), 2);

        // R10 flush keeps flag; R12 set wins over clear
        step(1, 0, 0, 1, 1, 8'h77);
        chk("R12 set wins", 64'(ovf_flag), 1);
        step(0, 0, 1, 0, 0, 8'h00);
        chk("R10 flag kept", 64'(ovf_flag), 1);
        chk("R10 level", 64'(level), 0);
        step(0, 1, 0, 0, 0, 8'h00);
        chk("R6 after flush", 64'(trap_cause), 3);
        step(0, 0, 0, 0, 1, 8'h00);
        chk("R12 clear", 64'(ovf_flag), 0);

        // R1 reset mid-run
        step(1, 0, 0, 1, 0, 8'h12);
        rst_n = 0;
        @(posedge clk); @(negedge clk);
        rst_n = 1;
        chk("R1 reset level", 64'(level), 0);
        chk("R1 reset flag", 64'(ovf_flag), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule